// File: doc/BRIEF.md
# FIFO Flag Threshold Programming Unit

This block stores the two threshold offsets that a FIFO's almost-empty and almost-full flag comparators use. The almost-empty offset is measured from the empty boundary and the almost-full offset from the full boundary. Each offset is a separate register and is programmed on its own. Both offsets are driven out at all times.

On the write clock, the offsets can be programmed in one of two ways. In serial mode, one bit arrives per clock on a serial input. In parallel mode, one chunk of a word arrives per clock on the data bus. A master reset chooses the mode from the load pin. It also loads a default into both offsets, and that default depends on the mode chosen. A partial reset keeps the mode and the offsets, and returns every sequence position to the start. On the read clock, the offsets can be read back chunk by chunk in either mode.

Readback has no back-pressure. Each readback request produces exactly one result on the next read-clock edge. The result is marked by a one-cycle valid strobe and stays on the output until the next request. The consumer must take a word on the cycle its valid is high. All other pins are plain level controls sampled on their clock.

Top module: `ofs_prog_unit`

## Requirements
- R1: A master reset (`mst_rst` high at a write-clock edge) sets the serial-mode output `ser_mode` to the value of `ld` at that edge. It loads both offsets with 1023 when `ld` is 1 and with 127 when `ld` is 0. It returns all sequence positions to the start. At the matching read-clock edge it clears `q_vld` and sets `q` to 0.
- R2: A partial reset (`part_rst` high) leaves `ser_mode`, `ae_ofs` and `af_ofs` unchanged. It returns the serial bit position, the parallel write position and the readback position to their first entry. While either reset is high, every load and readback request is ignored.
- R3: In serial mode, each write-clock edge with `ld` and `sen` both high writes `si` into the next offset bit and changes no other bit. Bits are taken least significant first: transfers 0 to 13 fill `ae_ofs` bits 0 to 13, and transfers 14 to 27 fill `af_ofs` bits 0 to 13. After the 28th transfer the position wraps to `ae_ofs` bit 0.
- R4: In parallel mode, each write-clock edge with `ld` and `wen` both high stores `din` into the next chunk. The chunk order is: `ae_ofs[8:0]`=`din[8:0]`, then `ae_ofs[13:9]`=`din[4:0]`, then `af_ofs[8:0]`, then `af_ofs[13:9]`, then back to the first. In a high chunk, `din[8:5]` has no effect.
- R5: In either mode, a read-clock edge with `ld` and `ren` both high returns the next chunk on `q` at the following edge, with `q_vld` high for that one cycle. The chunks come in the same four-step order as R4. A high chunk carries its five bits on `q[4:0]`, with `q[8:5]`=0.
- R6: In serial mode, requests on `wen` leave both offsets unchanged. In parallel mode, requests on `sen` leave both offsets unchanged. With `ld` low, neither `wen` nor `sen` changes the offsets.
- R7: When no readback is requested, `q` keeps its last value and `q_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock: programming and resets |
| rclk | input | 1 | Read clock: readback |
| mst_rst | input | 1 | Master reset, active high, synchronous to each clock |
| part_rst | input | 1 | Partial reset, active high, synchronous to each clock |
| ld | input | 1 | Load qualifier; selects the mode during master reset (1 = serial) |
| sen | input | 1 | Serial transfer request |
| si | input | 1 | Serial data bit |
| wen | input | 1 | Parallel transfer request |
| din | input | BUS_W | Parallel offset chunk |
| ren | input | 1 | Readback request |
| q | output | BUS_W | Readback chunk |
| q_vld | output | 1 | Readback result valid, one cycle per request |
| ser_mode | output | 1 | 1 when serial programming is selected |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |

## Verification
The assertions check several properties on every cycle. Each master reset must produce the default that matches the sampled `ld`. A partial reset must freeze the mode and both offsets. In each mode, the offsets must stay unchanged unless that mode's own request arrives. A serial transfer must touch at most one bit. The readback output must hold when idle, and a strobe must follow every request. Sequence counters must stay in range. Only the bench scenarios can show that bits and chunks land in the specified order and that positions wrap after the last entry. They also show that partial reset restarts the sequences and that readback returns the exact chunk values in order in both modes.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  // number of bus transfers needed for one offset register
  function automatic int chunks_per_reg(int ofs_w, int bus_w);
    return (ofs_w + bus_w - 1) / bus_w;
  endfunction
endpackage

// File: rtl/ofs_seq_counter.sv
module ofs_seq_counter #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  output logic [IW-1:0] idx
);
  always_ff @(posedge clk) begin
    if (clr)
      idx <= '0;
    else if (adv)
      idx <= (idx == IW'(N - 1)) ? '0 : idx + 1'b1;
  end

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (clr)
    32'(idx) < N);
endmodule

// File: rtl/ofs_regfile.sv
module ofs_regfile
  import ofs_pkg::*;
#(
  parameter int OFS_W   = 14,
  parameter int BUS_W   = 9,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic             clk,
  input  logic             mst_rst,
  input  logic             part_rst,
  input  logic             ld,
  input  logic             sen,
  input  logic             si,
  input  logic             wen,
  input  logic [BUS_W-1:0] din,
  output logic             ser_mode,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs
);
  localparam int CH   = chunks_per_reg(OFS_W, BUS_W);
  localparam int NBIT = 2 * OFS_W;
  localparam int NCHK = 2 * CH;
  localparam int BIW  = $clog2(NBIT);
  localparam int CIW  = (NCHK > 1) ? $clog2(NCHK) : 1;

  logic [OFS_W-1:0] ofs_q [2];
  logic [OFS_W-1:0] ofs_d [2];
  logic             ser_go, par_go;
  logic [BIW-1:0]   bit_idx;
  logic [CIW-1:0]   chk_idx;
  logic             s_sel, p_sel;
  logic [BIW-1:0]   s_pos;
  logic [CIW-1:0]   p_chk;

  assign ser_go = !mst_rst && !part_rst && ser_mode && ld && sen;
  assign par_go = !mst_rst && !part_rst && !ser_mode && ld && wen;

  ofs_seq_counter #(.N(NBIT)) u_bit_seq (
    .clk(clk), .clr(mst_rst | part_rst), .adv(ser_go), .idx(bit_idx));
  ofs_seq_counter #(.N(NCHK)) u_chk_seq (
    .clk(clk), .clr(mst_rst | part_rst), .adv(par_go), .idx(chk_idx));

  assign s_sel = (32'(bit_idx) >= OFS_W);
  assign s_pos = s_sel ? bit_idx - BIW'(OFS_W) : bit_idx;
  assign p_sel = (32'(chk_idx) >= CH);
  assign p_chk = p_sel ? chk_idx - CIW'(CH) : chk_idx;

  always_comb begin
    ofs_d[0] = ofs_q[0];
    ofs_d[1] = ofs_q[1];
    for (int b = 0; b < OFS_W; b++) begin
      if (ser_go && s_pos == BIW'(b))
        ofs_d[s_sel][b] = si;
      if (par_go && p_chk == CIW'(b / BUS_W))
        ofs_d[p_sel][b] = din[b % BUS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (mst_rst) begin
      ser_mode <= ld;
      ofs_q[0] <= ld ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR);
      ofs_q[1] <= ld ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR);
    end else if (!part_rst) begin
      ofs_q[0] <= ofs_d[0];
      ofs_q[1] <= ofs_d[1];
    end
  end

  assign ae_ofs = ofs_q[0];
  assign af_ofs = ofs_q[1];

  assert_mrst_default_R1: assert property (@(posedge clk) disable iff (part_rst)
    mst_rst |=> (ser_mode == $past(ld)) &&
                (ae_ofs == ($past(ld) ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR))) &&
                (af_ofs == ae_ofs));

  assert_prst_hold_R2: assert property (@(posedge clk) disable iff (mst_rst)
    part_rst |=> $stable(ae_ofs) && $stable(af_ofs) && $stable(ser_mode));

  assert_ser_one_bit_R3: assert property (@(posedge clk) disable iff (mst_rst)
    (ser_mode && ld && sen) |=>
      ($countones(ae_ofs ^ $past(ae_ofs)) + $countones(af_ofs ^ $past(af_ofs))) <= 1);

  assert_ser_filter_R6: assert property (@(posedge clk) disable iff (mst_rst)
    (ser_mode && !(ld && sen)) |=> $stable(ae_ofs) && $stable(af_ofs));

  assert_par_filter_R6: assert property (@(posedge clk) disable iff (mst_rst)
    (!ser_mode && !(ld && wen)) |=> $stable(ae_ofs) && $stable(af_ofs));
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
  import ofs_pkg::*;
#(
  parameter int OFS_W = 14,
  parameter int BUS_W = 9
) (
  input  logic             clk,
  input  logic             mst_rst,
  input  logic             part_rst,
  input  logic             ld,
  input  logic             ren,
  input  logic [OFS_W-1:0] ae_ofs,
  input  logic [OFS_W-1:0] af_ofs,
  output logic [BUS_W-1:0] q,
  output logic             q_vld
);
  localparam int CH   = chunks_per_reg(OFS_W, BUS_W);
  localparam int NCHK = 2 * CH;
  localparam int CIW  = (NCHK > 1) ? $clog2(NCHK) : 1;

  logic             rd_go;
  logic [CIW-1:0]   rd_idx;
  logic             r_sel;
  logic [CIW-1:0]   r_chk;
  logic [OFS_W-1:0] r_reg;
  logic [BUS_W-1:0] chunk;

  assign rd_go = !mst_rst && !part_rst && ld && ren;

  ofs_seq_counter #(.N(NCHK)) u_rd_seq (
    .clk(clk), .clr(mst_rst | part_rst), .adv(rd_go), .idx(rd_idx));

  assign r_sel = (32'(rd_idx) >= CH);
  assign r_chk = r_sel ? rd_idx - CIW'(CH) : rd_idx;
  assign r_reg = r_sel ? af_ofs : ae_ofs;

  always_comb begin
    chunk = '0;
    for (int b = 0; b < OFS_W; b++)
      if (r_chk == CIW'(b / BUS_W))
        chunk[b % BUS_W] = r_reg[b];
  end

  always_ff @(posedge clk) begin
    if (mst_rst) begin
      q     <= '0;
      q_vld <= 1'b0;
    end else begin
      q_vld <= rd_go;
      if (rd_go)
        q <= chunk;
    end
  end

  assert_q_hold_R7: assert property (@(posedge clk) disable iff (mst_rst)
    !(ren && ld) |=> $stable(q) && !q_vld);

  assert_q_strobe_R5: assert property (@(posedge clk) disable iff (mst_rst)
    (ren && ld && !part_rst) |=> q_vld);
endmodule

// File: rtl/ofs_prog_unit.sv
module ofs_prog_unit #(
  parameter int OFS_W   = 14,
  parameter int BUS_W   = 9,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             mst_rst,
  input  logic             part_rst,
  input  logic             ld,
  input  logic             sen,
  input  logic             si,
  input  logic             wen,
  input  logic [BUS_W-1:0] din,
  input  logic             ren,
  output logic [BUS_W-1:0] q,
  output logic             q_vld,
  output logic             ser_mode,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs
);
  ofs_regfile #(
    .OFS_W(OFS_W), .BUS_W(BUS_W), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)
  ) u_regs (
    .clk(wclk), .mst_rst(mst_rst), .part_rst(part_rst), .ld(ld),
    .sen(sen), .si(si), .wen(wen), .din(din),
    .ser_mode(ser_mode), .ae_ofs(ae_ofs), .af_ofs(af_ofs));

  ofs_readback #(.OFS_W(OFS_W), .BUS_W(BUS_W)) u_rdbk (
    .clk(rclk), .mst_rst(mst_rst), .part_rst(part_rst), .ld(ld),
    .ren(ren), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .q(q), .q_vld(q_vld));
endmodule

// File: tb/ofs_prog_unit_bench.sv
`timescale 1ns/1ps
module ofs_prog_unit_bench;
  localparam int OW = 14, BW = 9, CH = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic mst_rst = 0, part_rst = 0, ld = 0, sen = 0, si = 0, wen = 0, ren = 0;
  logic [BW-1:0] din = '0;
  logic [BW-1:0] q;
  logic q_vld, ser_mode;
  logic [OW-1:0] ae_ofs, af_ofs;

  ofs_prog_unit u_ofs_prog_unit (
    .wclk(clk), .rclk(clk), .mst_rst(mst_rst), .part_rst(part_rst), .ld(ld),
    .sen(sen), .si(si), .wen(wen), .din(din), .ren(ren), .q(q), .q_vld(q_vld),
    .ser_mode(ser_mode), .ae_ofs(ae_ofs), .af_ofs(af_ofs));

  int checks = 0, fails = 0;
  logic [BW-1:0] expq [$];
  logic [OW-1:0] m_reg [2];
  bit m_ser;
  int wptr, rptr, bptr;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_ofs(string req);
    chk(req, 32'(ae_ofs), 32'(m_reg[0]));
    chk(req, 32'(af_ofs), 32'(m_reg[1]));
    chk(req, 32'(ser_mode), 32'(m_ser));
  endtask

  task automatic do_mrst(bit l);
    @(negedge clk); mst_rst = 1; ld = l;
    @(negedge clk); mst_rst = 0; ld = 0;
    m_ser = l; m_reg[0] = l ? 14'd1023 : 14'd127; m_reg[1] = m_reg[0];
    wptr = 0; rptr = 0; bptr = 0;
  endtask

  task automatic do_prst();
    @(negedge clk); part_rst = 1;
    @(negedge clk); part_rst = 0;
    wptr = 0; rptr = 0; bptr = 0;
  endtask

  task automatic par_wr(logic [BW-1:0] d);
    @(negedge clk); ld = 1; wen = 1; din = d;
    @(negedge clk); ld = 0; wen = 0;
    if (!m_ser) begin
      for (int b = 0; b < OW; b++)
        if (b / BW == wptr % CH) m_reg[wptr / CH][b] = d[b % BW];
      wptr = (wptr + 1) % (2 * CH);
    end
  endtask

  task automatic ser_wr(logic s);
    @(negedge clk); ld = 1; sen = 1; si = s;
    @(negedge clk); ld = 0; sen = 0;
    if (m_ser) begin
      if (bptr < OW) m_reg[0][bptr] = s; else m_reg[1][bptr - OW] = s;
      bptr = (bptr + 1) % (2 * OW);
    end
  endtask

  task automatic rd_req();
    logic [BW-1:0] c;
    c = '0;
    for (int b = 0; b < OW; b++)
      if (b / BW == rptr % CH) c[b % BW] = m_reg[rptr / CH][b];
    expq.push_back(c);
    rptr = (rptr + 1) % (2 * CH);
    @(negedge clk); ld = 1; ren = 1;
    @(negedge clk); ld = 0; ren = 0;
  endtask

  // monitor: pop and compare each readback result
  always @(negedge clk) begin
    if (q_vld) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R5: unexpected q_vld, actual %0h expected none", q);
      end else begin
        logic [BW-1:0] e;
        e = expq.pop_front();
        if (q !== e) begin
          fails++;
          $display("FAIL R5: readback actual %0h expected %0h", q, e);
        end
      end
    end
  end

  task automatic finish_run();
    chk("R5 queue drained", 32'(expq.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] lastq;
    logic [OW-1:0] sv_ae, sv_af;
    repeat (2) @(negedge clk);

    // R1 parallel-mode master reset
    do_mrst(0);
    chk_ofs("R1 parallel default");
    chk("R1 q_vld low", 32'(q_vld), 0);
    chk("R1 q zero", 32'(q), 0);

    // R4 parallel load with junk in unused upper bits of high chunk
    par_wr(9'h15B);
    chk_ofs("R4 ae low chunk");
    par_wr(9'h1F5);
    chk_ofs("R4 ae high chunk");
    par_wr(9'h0A7);
    par_wr(9'h1E3);
    chk_ofs("R4 af chunks");
    par_wr(9'h033);
    chk_ofs("R4 wrap to ae low");

    // R5 readback in parallel mode, full cycle plus wrap
    repeat (5) rd_req();

    // R7 idle holds q
    @(negedge clk); lastq = q;
    @(negedge clk); ren = 1; ld = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R7 q hold", 32'(q), 32'(lastq));
      chk("R7 q_vld low", 32'(q_vld), 0);
    end
    ren = 0;

    // R6 in parallel mode: sen ignored, wen without ld ignored
    for (int i = 0; i < 3; i++) ser_wr(1'b1);
    chk_ofs("R6 sen ignored in parallel");
    @(negedge clk); wen = 1; din = 9'h1FF;
    @(negedge clk); wen = 0;
    chk_ofs("R6 wen without ld ignored");

    // R2 partial reset holds offsets and restarts sequences
    do_prst();
    chk_ofs("R2 offsets held parallel");
    par_wr(9'h0C4);
    chk_ofs("R2 write restarts at ae low");
    rd_req();
    do_prst();
    rd_req();

    // R1 serial-mode master reset
    do_mrst(1);
    chk_ofs("R1 serial default");

    // R3 serial load, 28 bits then one wrapped bit
    sv_ae = 14'h1A3C; sv_af = 14'h05E7;
    for (int i = 0; i < 2 * OW; i++)
      ser_wr(i < OW ? sv_ae[i] : sv_af[i - OW]);
    chk_ofs("R3 serial full load");
    chk("R3 ae value", 32'(ae_ofs), 32'(14'h1A3C));
    ser_wr(1'b1);
    chk_ofs("R3 wrap to ae bit0");

    // R6 in serial mode: wen ignored
    par_wr(9'h000); par_wr(9'h000);
    chk_ofs("R6 wen ignored in serial");

    // R5 readback in serial mode
    repeat (4) rd_req();

    // R2 partial reset mid serial sequence
    for (int i = 0; i < 5; i++) ser_wr(1'b0);
    do_prst();
    chk_ofs("R2 offsets held serial");
    ser_wr(1'b0); ser_wr(1'b1);
    chk_ofs("R2 serial restarts at bit0");

    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule